// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps calendar time: seconds, minutes, hours, day of week, day of month, month and a two-digit year from 00 to 99. Every field is held in BCD. Time advances only on a single-cycle 1 Hz enable strobe, which arrives in the block's own clock domain. February gets its extra day in leap years, and each month gets its proper length.

A new time is written into a set of staging registers while the live count keeps running. A commit write arms a load, and the staged value becomes the current time at the next strobe. That strobe would otherwise have added one second, so no second is lost or counted twice.

A date/time alarm compares year, month, day, hour and minute once per second. Each of the five fields has its own enable, and the alarm raises a one-cycle pulse on the first second of a match. A separate seconds timer raises a pulse either once after N seconds or every N seconds. Both interrupts and all settings are reached through a small flat register interface with an address, a write strobe, write data and combinational read data.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 0, day 01, month 01, year 00. The alarm enable mask, the timer reload and the timer control all read 0.
- R2: Seconds and minutes count 00 to 59 and hours count 00 to 23 in BCD, each wrapping with a carry into the next field. The time changes only on a cycle where `tick_1hz` is high.
- R3: Day of week counts 0 to 6, advances when the day of month rolls over, and wraps from 6 to 0.
- R4: Months 04, 06, 09 and 11 end after day 30, the other months except 02 end after day 31, and the day then returns to 01. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: February ends after day 29 when the year value is divisible by 4 (00 counts as a leap year), and after day 28 otherwise.
- R6: Writes to addresses 0 to 6 (second, minute, hour, day of week, day, month, year) change only the staging copy and leave the running count untouched. Writing bit 0 = 1 to address 7 makes the next tick load the staged copy as the current time instead of incrementing. The tick after that increments from the loaded value.
- R7: Address 13 bits [4:0] enable the alarm compare of minute, hour, day, month and year respectively (bit 0 = minute), against addresses 8 to 12 in that same field order. `alarm_irq` pulses for one cycle, two clock cycles after the tick on which all enabled fields first match. It does not pulse again while the match persists, and it never pulses when the mask is 0.
- R8: With several fields enabled, a mismatch in any one enabled field prevents the alarm.
- R9: Address 14 holds the timer reload N and address 15 the control (bit 0 run, bit 1 periodic). Writing control with run = 1 and N > 0 starts the timer. In one-shot mode `timer_irq` pulses once, in the cycle after the Nth tick, and run then reads 0.
- R10: In periodic mode `timer_irq` pulses after every N ticks and run stays set.
- R11: Register reads are combinational on `reg_addr`. Addresses 0 to 6 return the live time (day of week zero-extended), 8 to 14 return the written values, and 15 returns {periodic, run} in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| timer_irq | output | 1 | One-cycle timer pulse |

## Verification
The hardest situations to reach are the calendar boundaries: the last second of February in leap and common years, the last second of a 30-day month, and the last second of year 99. Reaching any of them by counting up from reset would take years of ticks. The bench instead stages a time one or two seconds before each boundary, commits it, and drives a few ticks across it. The same staged-load path sets the time just before a chosen minute, so the alarm's first-match pulse and its suppression on the following seconds can be observed within a handful of ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] day;
        logic [2:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{year: 8'h00, mon: 8'h01, day: 8'h01,
                                       wday: 3'd0, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // value mod 4 equals (2*tens + ones) mod 4
    function automatic logic is_leap(input logic [7:0] y);
        logic [4:0] s;
        s = 5'({y[7:4], 1'b0}) + 5'(y[3:0]);
        return s[1:0] == 2'd0;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t advance(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) begin
                n.min = bcd_inc(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hour != 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    n.wday = (t.wday >= 3'd6) ? 3'd0 : t.wday + 3'd1;
                    if (t.day != last_day(t.mon, is_leap(t.year))) begin
                        n.day = bcd_inc(t.day);
                    end else begin
                        n.day = 8'h01;
                        if (t.mon != 8'h12) begin
                            n.mon = bcd_inc(t.mon);
                        end else begin
                            n.mon  = 8'h01;
                            n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sh_we,
    input  logic [SEL_W-1:0] sh_sel,
    input  logic [7:0]       sh_data,
    input  logic             commit,
    output rtc_time_t        now_o
);

    typedef struct packed {
        rtc_time_t now;
        rtc_time_t shadow;
        logic      pend;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.pend) begin
                st_d.now  = st_q.shadow;
                st_d.pend = 1'b0;
            end else begin
                st_d.now = advance(st_q.now);
            end
        end
        if (sh_we) begin
            case (sh_sel)
                SEL_W'(0): st_d.shadow.sec  = sh_data;
                SEL_W'(1): st_d.shadow.min  = sh_data;
                SEL_W'(2): st_d.shadow.hour = sh_data;
                SEL_W'(3): st_d.shadow.wday = sh_data[2:0];
                SEL_W'(4): st_d.shadow.day  = sh_data;
                SEL_W'(5): st_d.shadow.mon  = sh_data;
                SEL_W'(6): st_d.shadow.year = sh_data;
                default: ;
            endcase
        end
        if (commit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.now    <= TIME_RST;
            st_q.shadow <= TIME_RST;
            st_q.pend   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_o = st_q.now;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.now)); // R2

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !st_q.pend && st_q.now.sec == 8'h59) |=> st_q.now.sec == 8'h00); // R2

    AST_LOAD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.pend) |=> st_q.now == $past(st_q.shadow)); // R6

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int NFLD  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  rtc_time_t        now,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [7:0]       cfg_data,
    output logic [7:0]       cfg_rd,
    output logic             irq
);

    typedef struct packed {
        logic [NFLD-1:0][7:0] ref_val;  // min, hour, day, mon, year
        logic [NFLD-1:0]      mask;
        logic                 tick_q;
        logic                 prev;
        logic                 irq;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic [NFLD-1:0][7:0] cur;
    logic [NFLD-1:0]      fld_ok;
    logic                 match;

    assign cur = {now.year, now.mon, now.day, now.hour, now.min};

    for (genvar g = 0; g < NFLD; g++) begin : g_cmp
        assign fld_ok[g] = !st_q.mask[g] || (cur[g] == st_q.ref_val[g]);
    end

    assign match = (st_q.mask != '0) && (&fld_ok);

    always_comb begin
        st_d        = st_q;
        st_d.tick_q = tick;
        st_d.irq    = 1'b0;
        if (st_q.tick_q) begin
            st_d.prev = match;
            st_d.irq  = match && !st_q.prev;
        end
        if (cfg_we) begin
            if (int'(cfg_sel) < NFLD)
                st_d.ref_val[cfg_sel] = cfg_data;
            else if (int'(cfg_sel) == NFLD)
                st_d.mask = cfg_data[NFLD-1:0];
        end
    end

    always_comb begin
        if (int'(cfg_sel) < NFLD)
            cfg_rd = st_q.ref_val[cfg_sel];
        else if (int'(cfg_sel) == NFLD)
            cfg_rd = 8'(st_q.mask);
        else
            cfg_rd = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    AST_ALARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq); // R7

    AST_ALARM_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |=> !st_q.irq); // R7

    AST_ALARM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(st_q.tick_q)); // R7

endmodule

// File: rtl/rtc_timer.sv
module rtc_timer #(
    parameter int TMR_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reload_we,
    input  logic       ctrl_we,
    input  logic [7:0] wdata,
    output logic [7:0] reload_rd,
    output logic [7:0] ctrl_rd,
    output logic       irq
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] reload;
        logic             run;
        logic             periodic;
        logic             irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (tick && st_q.run) begin
            if (st_q.cnt <= TMR_W'(1)) begin
                st_d.irq = 1'b1;
                if (st_q.periodic) st_d.cnt = st_q.reload;
                else               st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - TMR_W'(1);
            end
        end
        if (reload_we) st_d.reload = TMR_W'(wdata);
        if (ctrl_we) begin
            st_d.periodic = wdata[1];
            st_d.run      = wdata[0] && (st_d.reload != '0);
            st_d.cnt      = st_d.reload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_rd = 8'(st_q.reload);
    assign ctrl_rd   = {6'd0, st_q.periodic, st_q.run};
    assign irq       = st_q.irq;

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.run && !st_q.periodic && st_q.cnt == TMR_W'(1) && !ctrl_we)
        |=> !st_q.run); // R9

    AST_TIMER_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(tick)); // R10

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              alarm_irq,
    output logic              timer_irq
);

    localparam int SEL_W     = ADDR_W - 1;
    localparam int A_COMMIT  = 7;
    localparam int A_ALM_LO  = 8;
    localparam int A_RELOAD  = 14;
    localparam int A_CTRL    = 15;

    rtc_time_t        now;
    logic             hi_half;
    logic [SEL_W-1:0] sel;
    logic [7:0]       alm_rd, rld_rd, ctl_rd;
    logic             time_we, commit, alm_we, rld_we, ctl_we;

    assign hi_half = reg_addr[ADDR_W-1];
    assign sel     = reg_addr[SEL_W-1:0];
    assign time_we = reg_we && !hi_half && int'(sel) != A_COMMIT;
    assign commit  = reg_we && int'(reg_addr) == A_COMMIT && reg_wdata[0];
    assign alm_we  = reg_we && hi_half && int'(reg_addr) < A_RELOAD;
    assign rld_we  = reg_we && int'(reg_addr) == A_RELOAD;
    assign ctl_we  = reg_we && int'(reg_addr) == A_CTRL;

    rtc_counter #(.SEL_W(SEL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .sh_we   (time_we),
        .sh_sel  (sel),
        .sh_data (reg_wdata),
        .commit  (commit),
        .now_o   (now)
    );

    rtc_alarm #(.SEL_W(SEL_W), .NFLD(5)) u_alm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .now      (now),
        .cfg_we   (alm_we),
        .cfg_sel  (sel),
        .cfg_data (reg_wdata),
        .cfg_rd   (alm_rd),
        .irq      (alarm_irq)
    );

    rtc_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .reload_we (rld_we),
        .ctrl_we   (ctl_we),
        .wdata     (reg_wdata),
        .reload_rd (rld_rd),
        .ctrl_rd   (ctl_rd),
        .irq       (timer_irq)
    );

    always_comb begin
        reg_rdata = 8'h00;
        if (!hi_half) begin
            case (sel)
                SEL_W'(0): reg_rdata = now.sec;
                SEL_W'(1): reg_rdata = now.min;
                SEL_W'(2): reg_rdata = now.hour;
                SEL_W'(3): reg_rdata = {5'd0, now.wday};
                SEL_W'(4): reg_rdata = now.day;
                SEL_W'(5): reg_rdata = now.mon;
                SEL_W'(6): reg_rdata = now.year;
                default:   reg_rdata = 8'h00;
            endcase
        end else if (int'(reg_addr) == A_RELOAD) begin
            reg_rdata = rld_rd;
        end else if (int'(reg_addr) == A_CTRL) begin
            reg_rdata = ctl_rd;
        end else if (int'(reg_addr) >= A_ALM_LO) begin
            reg_rdata = alm_rd;
        end
    end

    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && now.wday <= 3'd6 && now.hour == 8'h23 && now.min == 8'h59
         && now.sec == 8'h59 && !commit) |=> now.wday <= 3'd6); // R3

endmodule

// File: tb/sim_cal_rtc.sv
module sim_cal_rtc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       alarm_irq, timer_irq;

    int n_chk = 0;
    int n_fail = 0;
    int alm_cnt = 0;
    int tmr_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cal_rtc u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .alarm_irq (alarm_irq),
        .timer_irq (timer_irq)
    );

    always @(negedge clk) begin
        if (rst_n && alarm_irq) alm_cnt++;
        if (rst_n && timer_irq) tmr_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, int'(rdata), int'(exp));
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, input logic [2:0] w,
                            input logic [7:0] h, mi, s);
        wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h); wr(4'd3, {5'd0, w});
        wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y); wr(4'd7, 8'h01);
        pulse(1);
    endtask

    task automatic t_reset;
        rd_chk(4'd0, 8'h00, "R1 sec");
        rd_chk(4'd1, 8'h00, "R1 min");
        rd_chk(4'd2, 8'h00, "R1 hour");
        rd_chk(4'd3, 8'h00, "R1 wday");
        rd_chk(4'd4, 8'h01, "R1 day");
        rd_chk(4'd5, 8'h01, "R1 mon");
        rd_chk(4'd6, 8'h00, "R1 year");
        rd_chk(4'd13, 8'h00, "R1 mask");
        rd_chk(4'd15, 8'h00, "R1 ctrl");
    endtask

    task automatic t_count;
        repeat (10) @(negedge clk);
        rd_chk(4'd0, 8'h00, "R2 no tick no change");
        pulse(10);
        rd_chk(4'd0, 8'h10, "R2 bcd seconds");
        set_time(8'h05, 8'h03, 8'h10, 3'd2, 8'h09, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd2, 8'h10, "R2 hour carry");
        rd_chk(4'd1, 8'h00, "R2 min wrap");
        rd_chk(4'd3, 8'h02, "R3 wday same day");
    endtask

    task automatic t_calendar;
        set_time(8'h99, 8'h12, 8'h31, 3'd6, 8'h23, 8'h59, 8'h58);
        rd_chk(4'd0, 8'h58, "R6 loaded sec");
        pulse(1);
        rd_chk(4'd0, 8'h59, "R6 increments after load");
        pulse(1);
        rd_chk(4'd6, 8'h00, "R4 year wrap");
        rd_chk(4'd5, 8'h01, "R4 month wrap");
        rd_chk(4'd4, 8'h01, "R4 day wrap");
        rd_chk(4'd3, 8'h00, "R3 wday wrap");
        rd_chk(4'd2, 8'h00, "R2 hour wrap");
        set_time(8'h07, 8'h04, 8'h30, 3'd1, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd5, 8'h05, "R4 30-day month");
        rd_chk(4'd4, 8'h01, "R4 30-day day");
        rd_chk(4'd3, 8'h02, "R3 wday step");
        set_time(8'h07, 8'h01, 8'h30, 3'd1, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd4, 8'h31, "R4 31-day month day 31");
        set_time(8'h24, 8'h02, 8'h28, 3'd3, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd4, 8'h29, "R5 leap feb 29");
        set_time(8'h24, 8'h02, 8'h29, 3'd4, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd5, 8'h03, "R5 leap to march");
        set_time(8'h23, 8'h02, 8'h28, 3'd2, 8'h23, 8'h59, 8'h59);
        pulse(1);
        rd_chk(4'd5, 8'h03, "R5 common year month");
        rd_chk(4'd4, 8'h01, "R5 common year day");
    endtask

    task automatic t_shadow;
        set_time(8'h10, 8'h06, 8'h15, 3'd1, 8'h12, 8'h00, 8'h20);
        wr(4'd0, 8'h45);
        wr(4'd1, 8'h33);
        pulse(1);
        rd_chk(4'd0, 8'h21, "R6 staged write ignored");
        rd_chk(4'd1, 8'h00, "R6 staged min ignored");
        wr(4'd7, 8'h01);
        rd_chk(4'd0, 8'h21, "R6 commit waits for tick");
        pulse(1);
        rd_chk(4'd0, 8'h45, "R6 load on tick");
        rd_chk(4'd1, 8'h33, "R6 load min");
        pulse(1);
        rd_chk(4'd0, 8'h46, "R6 no lost second");
    endtask

    task automatic t_alarm;
        wr(4'd8, 8'h05);
        rd_chk(4'd8, 8'h05, "R11 alarm min read");
        wr(4'd13, 8'h01);
        set_time(8'h10, 8'h06, 8'h15, 3'd1, 8'h12, 8'h04, 8'h58);
        alm_cnt = 0;
        pulse(1);
        check("R7 no alarm before match", alm_cnt, 0);
        pulse(1);
        check("R7 alarm on first match", alm_cnt, 1);
        pulse(4);
        check("R7 single pulse", alm_cnt, 1);
        wr(4'd9, 8'h13); wr(4'd10, 8'h15); wr(4'd11, 8'h06); wr(4'd12, 8'h50);
        wr(4'd13, 8'h1F);
        set_time(8'h10, 8'h06, 8'h15, 3'd1, 8'h13, 8'h04, 8'h59);
        alm_cnt = 0;
        pulse(3);
        check("R8 year mismatch blocks", alm_cnt, 0);
        wr(4'd13, 8'h00);
        set_time(8'h10, 8'h06, 8'h15, 3'd1, 8'h13, 8'h05, 8'h10);
        pulse(3);
        check("R7 mask zero silent", alm_cnt, 0);
    endtask

    task automatic t_timer;
        wr(4'd14, 8'd3);
        rd_chk(4'd14, 8'd3, "R11 reload read");
        wr(4'd15, 8'h01);
        tmr_cnt = 0;
        pulse(2);
        check("R9 not yet", tmr_cnt, 0);
        pulse(1);
        check("R9 fires after N", tmr_cnt, 1);
        rd_chk(4'd15, 8'h00, "R9 run cleared");
        pulse(5);
        check("R9 one shot only", tmr_cnt, 1);
        wr(4'd14, 8'd2);
        wr(4'd15, 8'h03);
        tmr_cnt = 0;
        pulse(6);
        check("R10 periodic count", tmr_cnt, 3);
        rd_chk(4'd15, 8'h03, "R10 run stays");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_calendar();
        t_shadow();
        t_alarm();
        t_timer();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule